// File: doc/BRIEF.md
# MAC Sequence Counter with Nonce Tracking

This block holds the 8-bit sequence value that a secure command processor mixes into each authenticated-encryption MAC, together with a flag telling whether the current session nonce may still be used. The cipher datapath, command parser and packet CRC checker stay outside. They show up here only as single-cycle event pulses: a nonce was generated, a MAC command is starting (one MAC, or two for a command that both checks and produces a MAC), a MAC compare failed, the packet had a CRC error, or a reset-class event happened (wake, reset command, tamper; power-up is the asynchronous reset).

For each accepted MAC command the block hands back, one clock later, the sequence value for every MAC the command may compute. It also pulses a refusal when the command needs a nonce it may no longer use. The count is bumped before use, so the first MAC of a session gets 1. The MAC that uses 255 ends the session: the nonce is dropped and the count returns to 0. The live count is always visible on a readback port for an info query.

Top module: `mac_seq_tracker`

## Requirements
- R1: During the asynchronous reset (rstN low), and one cycle after any of wakeEvt, resetCmdEvt or tamperEvt, infoCount is 0 and nonceValid is 0. All grant and reject outputs are 0 while rstN is low.
- R2: One cycle after nonceEvt, with crcErr low and no higher-priority event, infoCount is 0 and nonceValid is 1.
- R3: One cycle after macStart with macDual low, while nonceValid is 1, macGrantA pulses with macSeqA equal to the previous count plus 1, and the count becomes that value. The first MAC after a nonce therefore uses 1.
- R4: One cycle after macStart with macDual high, while nonceValid is 1 and the count is below 254, both macGrantA and macGrantB pulse. macSeqA is the count plus 1, macSeqB is the count plus 2, and the count advances by 2.
- R5: The counter never wraps. When a granted MAC uses the value 255, nonceValid is 0 and infoCount is 0 on the next cycle. For a dual command at count 254, macGrantA pulses with 255, macGrantB stays 0, and macReject pulses.
- R6: macStart while nonceValid is 0 gives a one-cycle macReject pulse, no grant, and an unchanged count.
- R7: When crcErr is high in the same cycle as macStart or nonceEvt, those events are ignored: no grant, no reject, and count and nonceValid are unchanged.
- R8: One cycle after cmpFail, infoCount is 0 and nonceValid is 0.
- R9: When events coincide, the highest one acts and the rest are dropped. The order, highest first, is: reset-class events, cmpFail, nonceEvt, macStart.
- R10: infoCount always shows the live counter value, which is the value the next MAC grant will build on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| wakeEvt | input | 1 | Wake-from-sleep pulse |
| resetCmdEvt | input | 1 | Reset-command pulse |
| tamperEvt | input | 1 | Tamper-detected pulse |
| nonceEvt | input | 1 | Nonce-generated pulse |
| crcErr | input | 1 | Current packet failed its CRC; qualifies nonceEvt and macStart |
| macStart | input | 1 | A MAC-type command is starting |
| macDual | input | 1 | With macStart: the command computes two MACs |
| cmpFail | input | 1 | A MAC comparison failed |
| nonceValid | output | 1 | Session nonce is usable |
| macGrantA | output | 1 | First MAC of the command granted (pulse) |
| macSeqA | output | 8 | Sequence value for the first MAC |
| macGrantB | output | 1 | Second MAC of a dual command granted (pulse) |
| macSeqB | output | 8 | Sequence value for the second MAC |
| macReject | output | 1 | Command, or its second MAC, refused for lack of a valid nonce (pulse) |
| infoCount | output | 8 | Live counter readback |

## Verification
A wrong count shows on infoCount in the cycle after the event that caused it. It also shows on macSeqA or macSeqB at the next grant, so the bench compares the readback every cycle and the sequence values at every grant. A wrong nonce flag shows at once on nonceValid. It also shows as a missing or spurious reject on the next MAC command. The directed cases walk the count up to the 253 and 254 corners, where a slip of one decides whether a dual command is refused.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;
  typedef struct packed {
    logic clr;      // counter back to zero
    logic stepOne;  // counter += 1
    logic stepTwo;  // counter += 2
    logic issueA;   // grant first MAC
    logic issueB;   // grant second MAC
    logic rej;      // refuse (whole command or its second MAC)
  } seqStrb_t;
endpackage

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import mac_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     clrEvt,
  input  logic     nonceEvt,
  input  logic     crcErr,
  input  logic     macStart,
  input  logic     macDual,
  input  logic     cmpFail,
  input  logic     firstAtMax,
  input  logic     secondAtMax,
  output seqStrb_t strb,
  output logic     nonceValid
);
  logic validNext;

  // Priority: reset-class > compare failure > nonce > MAC start
  always_comb begin
    strb      = '0;
    validNext = nonceValid;
    if (clrEvt) begin
      strb.clr  = 1'b1;
      validNext = 1'b0;
    end else if (cmpFail) begin
      strb.clr  = 1'b1;
      validNext = 1'b0;
    end else if (nonceEvt && !crcErr) begin
      strb.clr  = 1'b1;
      validNext = 1'b1;
    end else if (macStart && !crcErr) begin
      if (!nonceValid) begin
        strb.rej = 1'b1;
      end else begin
        strb.issueA = 1'b1;
        if (firstAtMax) begin
          strb.clr  = 1'b1;
          validNext = 1'b0;
          strb.rej  = macDual;
        end else if (macDual) begin
          strb.issueB = 1'b1;
          if (secondAtMax) begin
            strb.clr  = 1'b1;
            validNext = 1'b0;
          end else begin
            strb.stepTwo = 1'b1;
          end
        end else begin
          strb.stepOne = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nonceValid <= 1'b0;
    else       nonceValid <= validNext;
  end

  // R1: reset-class events drop the nonce
  p_clear_invalidates_r1: assert property (@(posedge clk) disable iff (!rstN)
    clrEvt |=> !nonceValid);
  // R2: a clean, unpreempted nonce command makes the nonce usable
  p_nonce_sets_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (nonceEvt && !crcErr && !clrEvt && !cmpFail) |=> nonceValid);
  // R4: a second MAC is never granted without the first
  p_dual_needs_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueB |-> strb.issueA);
  // R6: no grant is issued without a valid nonce
  p_grant_needs_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueA |-> nonceValid);
  // R8: compare failure drops the nonce
  p_cmpfail_invalidates_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpFail |=> !nonceValid);
endmodule

// File: rtl/mac_seq_dp.sv
module mac_seq_dp
  import mac_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  output logic             firstAtMax,
  output logic             secondAtMax,
  output logic [CNT_W-1:0] count,
  output logic             grantA,
  output logic [CNT_W-1:0] seqA,
  output logic             grantB,
  output logic [CNT_W-1:0] seqB,
  output logic             reject
);
  localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic [CNT_W-1:0] plusOne, plusTwo, countNext;

  assign plusOne     = count + ONE;
  assign plusTwo     = count + TWO;
  assign firstAtMax  = (plusOne == MAX_VAL);
  assign secondAtMax = (plusTwo == MAX_VAL);

  always_comb begin
    countNext = count;
    if (strb.clr)          countNext = '0;
    else if (strb.stepTwo) countNext = plusTwo;
    else if (strb.stepOne) countNext = plusOne;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      grantA <= 1'b0;
      grantB <= 1'b0;
      reject <= 1'b0;
      seqA   <= '0;
      seqB   <= '0;
    end else begin
      count  <= countNext;
      grantA <= strb.issueA;
      grantB <= strb.issueB;
      reject <= strb.rej;
      if (strb.issueA) seqA <= plusOne;
      if (strb.issueB) seqB <= plusTwo;
    end
  end

  // R5: without a clear the counter only moves upward (never wraps)
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clr |=> count >= $past(count));
  // R3: a granted value is never zero
  p_seq_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    grantA |-> seqA != '0);
  // R6: a refused command leaves the counter alone
  p_reject_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rej && !strb.issueA) |=> $stable(count));
endmodule

// File: rtl/mac_seq_tracker.sv
module mac_seq_tracker
  import mac_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wakeEvt,
  input  logic             resetCmdEvt,
  input  logic             tamperEvt,
  input  logic             nonceEvt,
  input  logic             crcErr,
  input  logic             macStart,
  input  logic             macDual,
  input  logic             cmpFail,
  output logic             nonceValid,
  output logic             macGrantA,
  output logic [CNT_W-1:0] macSeqA,
  output logic             macGrantB,
  output logic [CNT_W-1:0] macSeqB,
  output logic             macReject,
  output logic [CNT_W-1:0] infoCount
);
  seqStrb_t strb;
  logic     clrEvt, firstAtMax, secondAtMax;

  assign clrEvt = wakeEvt | resetCmdEvt | tamperEvt;

  mac_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clrEvt(clrEvt), .nonceEvt(nonceEvt),
    .crcErr(crcErr), .macStart(macStart), .macDual(macDual),
    .cmpFail(cmpFail), .firstAtMax(firstAtMax), .secondAtMax(secondAtMax),
    .strb(strb), .nonceValid(nonceValid)
  );

  mac_seq_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .firstAtMax(firstAtMax), .secondAtMax(secondAtMax),
    .count(infoCount), .grantA(macGrantA), .seqA(macSeqA),
    .grantB(macGrantB), .seqB(macSeqB), .reject(macReject)
  );

  // R10: a single grant advances the readback by exactly one unless the session ends
  p_info_tracks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (macGrantA && !macGrantB && nonceValid) |-> infoCount == macSeqA);
endmodule

// File: tb/mac_seq_tracker_test.sv
`timescale 1ns/1ps
module mac_seq_tracker_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeEvt = 0, resetCmdEvt = 0, tamperEvt = 0, nonceEvt = 0;
  logic crcErr = 0, macStart = 0, macDual = 0, cmpFail = 0;
  logic nonceValid, macGrantA, macGrantB, macReject;
  logic [7:0] macSeqA, macSeqB, infoCount;

  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  // bench model state
  int mCount = 0;
  bit mValid = 0;
  bit eGA, eGB, eRej;
  int eSA, eSB;

  always #2.5 clk = ~clk;

  mac_seq_tracker uut (
    .clk(clk), .rstN(rstN), .wakeEvt(wakeEvt), .resetCmdEvt(resetCmdEvt),
    .tamperEvt(tamperEvt), .nonceEvt(nonceEvt), .crcErr(crcErr),
    .macStart(macStart), .macDual(macDual), .cmpFail(cmpFail),
    .nonceValid(nonceValid), .macGrantA(macGrantA), .macSeqA(macSeqA),
    .macGrantB(macGrantB), .macSeqB(macSeqB), .macReject(macReject),
    .infoCount(infoCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected behaviour from the requirements
  task automatic modelStep();
    eGA = 0; eGB = 0; eRej = 0;
    if (wakeEvt || resetCmdEvt || tamperEvt || cmpFail) begin
      mCount = 0; mValid = 0;
    end else if (nonceEvt && !crcErr) begin
      mCount = 0; mValid = 1;
    end else if (macStart && !crcErr) begin
      if (!mValid) eRej = 1;
      else begin
        eGA = 1; eSA = mCount + 1;
        if (eSA == 255) begin
          mCount = 0; mValid = 0; eRej = macDual;
        end else if (macDual) begin
          eGB = 1; eSB = mCount + 2;
          if (eSB == 255) begin mCount = 0; mValid = 0; end
          else mCount = eSB;
        end else mCount = eSA;
      end
    end
  endtask

  task automatic compareAll();
    check(infoCount == mCount, "R10 infoCount", infoCount, mCount);
    check(nonceValid == mValid, "R2 nonceValid", nonceValid, mValid);
    check(macGrantA == eGA, "R3 macGrantA", macGrantA, eGA);
    check(macGrantB == eGB, "R4 macGrantB", macGrantB, eGB);
    check(macReject == eRej, "R6 macReject", macReject, eRej);
    if (eGA) check(macSeqA == eSA, "R3 macSeqA", macSeqA, eSA);
    if (eGB) check(macSeqB == eSB, "R4 macSeqB", macSeqB, eSB);
  endtask

  // inputs applied after a falling edge, results sampled at the next falling edge
  task automatic drive(input bit w, input bit rc, input bit t, input bit n,
                       input bit crc, input bit ms, input bit md, input bit cf);
    wakeEvt = w; resetCmdEvt = rc; tamperEvt = t; nonceEvt = n;
    crcErr = crc; macStart = ms; macDual = md; cmpFail = cf;
    modelStep();
    @(negedge clk);
    compareAll();
    {wakeEvt, resetCmdEvt, tamperEvt, nonceEvt, crcErr, macStart, macDual, cmpFail} = '0;
  endtask

  task automatic idle(); drive(0,0,0,0,0,0,0,0); endtask
  task automatic single(); drive(0,0,0,0,0,1,0,0); endtask
  task automatic dual(); drive(0,0,0,0,0,1,1,0); endtask
  task automatic nonce(); drive(0,0,0,1,0,0,0,0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (2) @(negedge clk);
    // R1: reset state
    check(infoCount == 0, "R1 count in reset", infoCount, 0);
    check(nonceValid == 0, "R1 valid in reset", nonceValid, 0);
    check(macGrantA == 0 && macReject == 0, "R1 pulses in reset", macGrantA, 0);
    rstN = 1'b1;
    idle();

    // R6: MAC command with no nonce
    single();
    check(macReject == 1 && infoCount == 0, "R6 reject without nonce", macReject, 1);

    // R2, R3, R4: first MACs after a nonce use 1, then 2 and 3
    nonce();
    single();
    check(macSeqA == 1, "R3 first MAC uses 1", macSeqA, 1);
    dual();
    check(macSeqA == 2 && macSeqB == 3, "R4 dual pair 2/3", macSeqB, 3);

    // R7: CRC error hides MAC start and nonce
    drive(0,0,0,0,1,1,1,0);
    check(infoCount == 3 && !macGrantA && !macReject, "R7 crc ignored", infoCount, 3);
    drive(0,0,0,1,1,0,0,0);
    check(infoCount == 3, "R7 crc nonce ignored", infoCount, 3);

    // R5: dual at 253 ends on 255
    while (mCount < 253) single();
    dual();
    check(macSeqB == 255 && !nonceValid && infoCount == 0, "R5 dual ends at 255", macSeqB, 255);
    // R5: dual at 254 -> first 255, second refused
    nonce();
    while (mCount < 254) single();
    dual();
    check(macGrantA && macSeqA == 255 && !macGrantB && macReject, "R5 dual at 254", macSeqA, 255);
    check(!nonceValid && infoCount == 0, "R5 invalid after limit", nonceValid, 0);
    single();
    check(macReject == 1, "R5 reject after limit", macReject, 1);

    // R8: compare failure
    nonce(); single(); single();
    drive(0,0,0,0,0,0,0,1);
    check(!nonceValid && infoCount == 0, "R8 cmpFail clears", nonceValid, 0);

    // R1: each reset-class source
    nonce(); single(); drive(1,0,0,0,0,0,0,0);
    check(!nonceValid && infoCount == 0, "R1 wake clears", infoCount, 0);
    nonce(); single(); drive(0,1,0,0,0,0,0,0);
    check(!nonceValid, "R1 reset command clears", nonceValid, 0);
    nonce(); single(); drive(0,0,1,0,0,0,0,0);
    check(!nonceValid, "R1 tamper clears", nonceValid, 0);

    // R9: priority
    drive(0,0,1,1,0,0,0,0);
    check(!nonceValid, "R9 tamper over nonce", nonceValid, 0);
    nonce(); single();
    drive(0,0,0,0,0,1,0,1);
    check(!macGrantA && !nonceValid, "R9 cmpFail over MAC", macGrantA, 0);
    nonce(); single(); single();
    drive(0,0,0,1,0,1,0,0);
    check(!macGrantA && infoCount == 0 && nonceValid, "R9 nonce over MAC", infoCount, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit w, rc, t, n, crc, ms, md, cf;
      w   = ($urandom % 400) == 0;
      rc  = ($urandom % 400) == 0;
      t   = ($urandom % 400) == 0;
      cf  = ($urandom % 150) == 0;
      n   = ($urandom % 60) == 0;
      crc = ($urandom % 10) == 0;
      ms  = ($urandom % 2) == 0;
      md  = ($urandom % 3) == 0;
      drive(w, rc, t, n, crc, ms, md, cf);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule